// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block drives one pulse-width-modulated output from three numbers and a handful of control levels supplied by a neighbouring register block. A prescaler divides the system clock into ticks. A period counter counts those ticks, and a comparator sets the output active while the tick count is below the duty value. The full output period is therefore (prescale+1)*(period+1) system clocks. The block also emits a one-clock pulse in the last clock of every period, which the surrounding logic can use as a boundary marker.

Software-visible values are written into the register block at any time. The generator captures them into its own working copies when a channel starts, at a period boundary when automatic reload is on, or at once when a forced load is requested. This means a running waveform never shows a period of mixed settings. Stopping can either let the current period finish or cut the output on the next clock. An internal two-flop stage releases the asynchronous reset synchronously.

Top module: `pwm_chan_gen`

## Requirements
- R1: While reset is applied, and after release with the channel disabled, pwm_out is 0 and period_tick is 0 (invert low).
- R2: An output period lasts (cfg_prescale+1)*(cfg_period+1) clocks, and period_tick is 1 only in the last clock of each period.
- R3: Within a period, tick index i (0..cfg_period) is active when i < duty. A duty of 0 is never active, and a duty above the period value is active for the whole period.
- R4: pwm_out equals the active level XOR ctl_invert, so a disabled channel rests at the ctl_invert level.
- R5: When ctl_enable rises on an idle channel, it captures all three configuration values and the first period starts on the next clock.
- R6: With ctl_autoload low, configuration changes made while running have no effect on the waveform.
- R7: With ctl_autoload high, new configuration takes effect at the next period boundary and never within a period.
- R8: When ctl_enable is cleared with ctl_stop_now low, the current period completes and the output then goes to the resting level.
- R9: When ctl_enable is low and ctl_stop_now is high, the output goes to the resting level from the next clock.
- R10: A cycle with ctl_load_period high on a running channel captures cfg_period, restarts both counters on the next clock and leaves the working duty unchanged.
- R11: A cycle with ctl_load_prescale high on a running channel captures cfg_prescale and restarts only the prescaler; the period count continues.
- R12: period_tick is never asserted while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 10 | Clock divide value minus one |
| cfg_period | input | 12 | Ticks per period minus one |
| cfg_duty | input | 12 | Active ticks per period |
| ctl_enable | input | 1 | Run request |
| ctl_invert | input | 1 | Output polarity flip |
| ctl_autoload | input | 1 | Reload configuration at period boundaries |
| ctl_stop_now | input | 1 | Abort the current period when disabling |
| ctl_load_prescale | input | 1 | Force capture of the prescale value |
| ctl_load_period | input | 1 | Force capture of the period value and restart |
| pwm_out | output | 1 | PWM waveform |
| period_tick | output | 1 | One-clock pulse in the last clock of a period |

## Verification
On every cycle the assertions check the resting level while idle, the absence of boundary pulses while idle, a zero duty holding the output at rest, the one-clock shutdown on an immediate stop, continued running during a graceful stop until the boundary, and that the working period value moves only at a boundary or on a forced load. Exact period lengths, the placement of the active window, whether a new configuration lands at the right boundary and not earlier, and the differing restart effects of the two forced loads can only be shown by the bench's scenarios. The bench compares every clock of the waveform against an expected sequence built from the requirements.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned PRE_W_DEF = 10;
  localparam int unsigned PER_W_DEF = 12;

  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;
endpackage

// File: rtl/pwm_run_ctl.sv
module pwm_run_ctl
  import pwm_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stop_now,
  input  logic wrap,
  output logic running,
  output logic start
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    case (state_q)
      RUN_IDLE: begin
        if (enable) begin
          state_d = RUN_ACTIVE;
          start   = 1'b1;
        end
      end
      RUN_ACTIVE: begin
        if (!enable && (stop_now || wrap)) begin
          state_d = RUN_IDLE;
        end
      end
      default: state_d = RUN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign running = (state_q == RUN_ACTIVE);
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int unsigned PRE_W = 10,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_all,
  input  logic             force_pre,
  input  logic             force_per,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic [PER_W-1:0] cfg_per,
  input  logic [PER_W-1:0] cfg_duty,
  output logic [PRE_W-1:0] wk_pre,
  output logic [PER_W-1:0] wk_per,
  output logic [PER_W-1:0] wk_duty
);
  logic [PRE_W-1:0] pre_d;
  logic [PER_W-1:0] per_d;
  logic [PER_W-1:0] duty_d;
  logic             pre_en, per_en, duty_en;

  always_comb begin
    pre_en  = load_all | force_pre;
    per_en  = load_all | force_per;
    duty_en = load_all;
    pre_d   = pre_en  ? cfg_pre  : wk_pre;
    per_d   = per_en  ? cfg_per  : wk_per;
    duty_d  = duty_en ? cfg_duty : wk_duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wk_pre  <= '0;
      wk_per  <= '0;
      wk_duty <= '0;
    end else begin
      wk_pre  <= pre_d;
      wk_per  <= per_d;
      wk_duty <= duty_d;
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] wk_pre,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;

  always_comb begin
    at_top = (cnt_q == wk_pre);
    tick   = run & at_top;
    if (!run || restart || at_top) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] wk_per,
  input  logic [W-1:0] wk_duty,
  output logic         wrap,
  output logic         active
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap   = tick & (cnt_q == wk_per);
    active = run & (cnt_q < wk_duty);
    if (!run || restart || wrap) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
  import pwm_chan_pkg::*;
#(
  parameter int unsigned PRE_W = PRE_W_DEF,
  parameter int unsigned PER_W = PER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [PER_W-1:0] cfg_duty,
  input  logic             ctl_enable,
  input  logic             ctl_invert,
  input  logic             ctl_autoload,
  input  logic             ctl_stop_now,
  input  logic             ctl_load_prescale,
  input  logic             ctl_load_period,
  output logic             pwm_out,
  output logic             period_tick
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;
  logic                   running, start, wrap, tick, active;
  logic                   load_all, force_pre, force_per, restart_pre;
  logic [PRE_W-1:0]       wk_pre;
  logic [PER_W-1:0]       wk_per, wk_duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    load_all    = start | (running & wrap & ctl_enable & ctl_autoload);
    force_pre   = running & ctl_load_prescale;
    force_per   = running & ctl_load_period;
    restart_pre = force_pre | force_per;
  end

  pwm_run_ctl u_run (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable   (ctl_enable),
    .stop_now (ctl_stop_now),
    .wrap     (wrap),
    .running  (running),
    .start    (start)
  );

  pwm_shadow_regs #(.PRE_W(PRE_W), .PER_W(PER_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_all  (load_all),
    .force_pre (force_pre),
    .force_per (force_per),
    .cfg_pre   (cfg_prescale),
    .cfg_per   (cfg_period),
    .cfg_duty  (cfg_duty),
    .wk_pre    (wk_pre),
    .wk_per    (wk_per),
    .wk_duty   (wk_duty)
  );

  pwm_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (running),
    .restart (restart_pre),
    .wk_pre  (wk_pre),
    .tick    (tick)
  );

  pwm_period_ctr #(.W(PER_W)) u_per (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (running),
    .restart (force_per),
    .tick    (tick),
    .wk_per  (wk_per),
    .wk_duty (wk_duty),
    .wrap    (wrap),
    .active  (active)
  );

  assign pwm_out     = active ^ ctl_invert;
  assign period_tick = wrap;
endmodule

// File: rtl/pwm_chan_gen_chk.sv
module pwm_chan_gen_chk #(
  parameter int unsigned PER_W = 12
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             running,
  input logic             ctl_enable,
  input logic             ctl_stop_now,
  input logic             ctl_invert,
  input logic             ctl_load_period,
  input logic             pwm_out,
  input logic             period_tick,
  input logic [PER_W-1:0] wk_per,
  input logic [PER_W-1:0] wk_duty
);
  always @(posedge clk) begin
    if (!rst_core_n) begin
      AST_RESET_QUIET: assert (period_tick == 1'b0); // R1
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !running |-> (pwm_out == ctl_invert)); // R4

  AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_core_n)
    period_tick |-> running); // R12

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (running && wk_duty == '0) |-> (pwm_out == ctl_invert)); // R3

  AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (running && !ctl_enable && ctl_stop_now) |=> !running); // R9

  AST_GRACEFUL_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (running && !ctl_enable && !ctl_stop_now && !period_tick) |=> running); // R8

  AST_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (running && !period_tick && !ctl_load_period) |=> $stable(wk_per)); // R7
endmodule

bind pwm_chan_gen pwm_chan_gen_chk #(.PER_W(PER_W)) u_chk (
  .clk             (clk),
  .rst_core_n      (rst_core_n),
  .running         (running),
  .ctl_enable      (ctl_enable),
  .ctl_stop_now    (ctl_stop_now),
  .ctl_invert      (ctl_invert),
  .ctl_load_period (ctl_load_period),
  .pwm_out         (pwm_out),
  .period_tick     (period_tick),
  .wk_per          (wk_per),
  .wk_duty         (wk_duty)
);

// File: tb/pwm_chan_gen_tb.sv
`timescale 1ns/1ps
module pwm_chan_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  cfg_prescale;
  logic [11:0] cfg_period, cfg_duty;
  logic        ctl_enable, ctl_invert, ctl_autoload, ctl_stop_now;
  logic        ctl_load_prescale, ctl_load_period;
  logic        pwm_out, period_tick;

  always #2.5 clk = ~clk;

  pwm_chan_gen u_dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_prescale (cfg_prescale), .cfg_period (cfg_period), .cfg_duty (cfg_duty),
    .ctl_enable (ctl_enable), .ctl_invert (ctl_invert), .ctl_autoload (ctl_autoload),
    .ctl_stop_now (ctl_stop_now), .ctl_load_prescale (ctl_load_prescale),
    .ctl_load_period (ctl_load_period),
    .pwm_out (pwm_out), .period_tick (period_tick)
  );

  typedef struct {
    logic  pwm;
    logic  tick;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.req, " pwm_out"}, {31'b0, pwm_out}, {31'b0, e.pwm});
      check({e.req, " period_tick"}, {31'b0, period_tick}, {31'b0, e.tick});
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    step(q.size());
  endtask

  task automatic push(logic p, logic t, string r);
    exp_t e;
    e.pwm = p; e.tick = t; e.req = r;
    q.push_back(e);
  endtask

  task automatic push_idle(int n, logic inv, string r);
    for (int i = 0; i < n; i++) push(inv, 1'b0, r);
  endtask

  task automatic push_period(int pre, int per, int duty, logic inv, string r);
    int total;
    total = (pre + 1) * (per + 1);
    for (int k = 0; k < total; k++) begin
      push(((k / (pre + 1)) < duty) ^ inv, (k == total - 1), r);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0;
    cfg_prescale = '0; cfg_period = '0; cfg_duty = '0;
    ctl_enable = 0; ctl_invert = 0; ctl_autoload = 0; ctl_stop_now = 0;
    ctl_load_prescale = 0; ctl_load_period = 0;
    step(3);
    check("R1 reset pwm_out", {31'b0, pwm_out}, 32'd0);
    check("R1 reset period_tick", {31'b0, period_tick}, 32'd0);
    rst_n = 1'b1;
    step(4);
    check("R1 idle pwm_out", {31'b0, pwm_out}, 32'd0);
    check("R1 idle period_tick", {31'b0, period_tick}, 32'd0);

    // R5 + R2 + R3: start with prescale 0, period 3, duty 2
    cfg_prescale = 10'd0; cfg_period = 12'd3; cfg_duty = 12'd2;
    ctl_enable = 1;
    push_idle(1, 0, "R5");
    push_period(0, 3, 2, 0, "R2");
    push_period(0, 3, 2, 0, "R3");
    drain();

    // R6: no autoload, new values ignored
    cfg_prescale = 10'd1; cfg_period = 12'd2; cfg_duty = 12'd1;
    push_period(0, 3, 2, 0, "R6");
    push_period(0, 3, 2, 0, "R6");
    drain();

    // R7: autoload takes effect at the next boundary only
    ctl_autoload = 1;
    push_period(0, 3, 2, 0, "R7");
    push_period(1, 2, 1, 0, "R7");
    push_period(1, 2, 1, 0, "R2");
    drain();

    // R3: duty zero, then duty beyond the period
    cfg_duty = 12'd0;
    push_period(1, 2, 1, 0, "R7");
    push_period(1, 2, 0, 0, "R3");
    drain();
    cfg_duty = 12'd5;
    push_period(1, 2, 0, 0, "R3");
    push_period(1, 2, 5, 0, "R3");
    drain();

    // R4: polarity flip applies at once
    ctl_invert = 1; cfg_duty = 12'd1;
    push_period(1, 2, 5, 1, "R4");
    push_period(1, 2, 1, 1, "R4");
    drain();

    // R8: graceful disable, rest level high
    ctl_enable = 0;
    push_period(1, 2, 1, 1, "R8");
    push_idle(4, 1, "R8");
    drain();

    // R9: immediate stop
    ctl_invert = 0; ctl_autoload = 0;
    cfg_prescale = 10'd2; cfg_period = 12'd3; cfg_duty = 12'd2;
    ctl_enable = 1;
    push_idle(1, 0, "R5");
    push_period(2, 3, 2, 0, "R2");
    drain();
    ctl_enable = 0; ctl_stop_now = 1;
    push(1'b1, 1'b0, "R9");
    push_idle(4, 0, "R9");
    drain();
    ctl_stop_now = 0;

    // R10: forced period load restarts counters, duty kept
    cfg_prescale = 10'd1; cfg_period = 12'd3; cfg_duty = 12'd2;
    ctl_enable = 1;
    push_idle(1, 0, "R5");
    push_period(1, 3, 2, 0, "R2");
    drain();
    cfg_period = 12'd1; cfg_duty = 12'd1; ctl_load_period = 1;
    push(1'b1, 1'b0, "R10");
    drain();
    ctl_load_period = 0;
    push_period(1, 1, 2, 0, "R10");
    push_period(1, 1, 2, 0, "R10");
    drain();

    // R11: forced prescale load restarts only the prescaler
    cfg_prescale = 10'd0; ctl_load_prescale = 1;
    push(1'b1, 1'b0, "R11");
    drain();
    ctl_load_prescale = 0;
    push_period(0, 1, 2, 0, "R11");
    push_period(0, 1, 2, 0, "R11");
    drain();

    // R12: after stop, no boundary pulse while idle
    ctl_enable = 0; ctl_stop_now = 1;
    push(1'b1, 1'b0, "R9");
    push_idle(6, 0, "R12");
    drain();
    ctl_stop_now = 0;

    step(2);
    report();
  end
endmodule